// File: doc/BRIEF.md
# Packet Hold and Byte Access Stage

This stage sits between an input frame queue and a packet-processing engine. The queue delivers one packet as a run of 32-byte frames. The final frame carries a marker and a count of the bytes it holds. The stage stores the whole packet in local storage, records its length in bytes, and then pulses a start signal to the engine. While the engine's program runs, the stage serves single-byte reads and writes to the stored packet over a simple address/data port. Reads past the recorded length return zero.

When the engine finishes, it presents a three-bit verdict. Some verdicts discard the packet. The others send the buffered packet, with any edits the program made, out as a stream of frames tagged with a destination. After that, the next packet is accepted. Only one packet is held at a time, so the input queue is stalled from the moment a packet is complete until its verdict has been fully carried out.

A packet longer than the storage is still taken off the queue in full, so the queue never stalls on it. Frames past the capacity are thrown away, the packet is dropped without starting the engine, and the stage then waits for the next packet.

Top module: `pkt_hold_unit`

## Requirements
- R1: `rx_ready` is high while the stage waits for a packet. It is low from the cycle after the final frame of a stored packet is accepted until the cycle after its last output frame is taken, or the cycle after a discarding verdict.
- R2: `run_start` is high for exactly one cycle: the cycle after an edge that accepts a final frame (`rx_last`=1) of a packet that fit in storage. It stays low for a packet that did not fit.
- R3: From the `run_start` cycle until the next packet completes, `pkt_len` equals 32 times the number of earlier frames, plus `rx_nbytes` of the final frame. `rx_nbytes` lies in 1..32; earlier frames are full.
- R4: A read (`mem_en`=1, `mem_we`=0) while the program runs returns the byte at `mem_addr` on `mem_rdata` in the next cycle. Byte k of a frame occupies bits 8k+7..8k of `rx_data`, and packet byte address a is byte a mod 32 of frame a/32.
- R5: A read at an address equal to or above `pkt_len` returns zero.
- R6: A write (`mem_en`=1, `mem_we`=1) below `pkt_len` while the program runs replaces that byte. Later reads and the output stream both see the new value.
- R7: Verdict codes 0 (aborted) and 1 (drop), and the unused codes 5 to 7, discard the packet. No output frame appears and `rx_ready` is high in the next cycle.
- R8: Verdict codes 2 (to host), 3 (out on the wire) and 4 (redirect) raise `tx_valid` in the next cycle and send the packet's frames in order. `tx_last` marks the final frame. `tx_nbytes` is 32 on every frame except the final one, where it equals the final input frame's byte count. Output bytes below that count match the stored packet. `tx_dest` is 0 for code 2, 1 for code 3 and 2 for code 4.
- R9: While `tx_valid` is high and `tx_ready` is low, the frame on offer does not advance.
- R10: A packet of more than MAX_BYTES/32 frames is accepted in full with `rx_ready` high throughout. It produces no `run_start`, and the next packet is then stored and handled normally.
- R11: `vd_valid` has no effect while no program is running. Output stays idle and `rx_ready` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_valid | input | 1 | Input frame present |
| rx_ready | output | 1 | Stage accepts an input frame |
| rx_data | input | 8*FRAME_BYTES | Input frame bytes, byte 0 in the low bits |
| rx_last | input | 1 | Final frame of the packet |
| rx_nbytes | input | clog2(FRAME_BYTES+1) | Byte count of the final frame |
| run_start | output | 1 | One-cycle start pulse to the engine |
| pkt_len | output | clog2(MAX_BYTES+1) | Length in bytes of the held packet |
| mem_en | input | 1 | Byte access request |
| mem_we | input | 1 | Access is a write |
| mem_addr | input | clog2(MAX_BYTES) | Packet byte address |
| mem_wdata | input | 8 | Write byte |
| mem_rdata | output | 8 | Read byte, one cycle after the request |
| vd_valid | input | 1 | Verdict present |
| vd_code | input | 3 | Verdict code |
| tx_valid | output | 1 | Output frame present |
| tx_ready | input | 1 | Output frame taken |
| tx_data | output | 8*FRAME_BYTES | Output frame bytes |
| tx_last | output | 1 | Final output frame |
| tx_nbytes | output | clog2(FRAME_BYTES+1) | Valid bytes in the output frame |
| tx_dest | output | 2 | 0 host, 1 wire, 2 redirect |

## Verification
The hardest cases to reach from the ports are packet lengths that end on an exact frame boundary, lengths one byte past such a boundary, and a packet that overruns storage by exactly one frame. The bench uses a four-frame build and sweeps every length from 1 to 128 bytes, which covers every tail size at every frame count. It then feeds a five-frame packet followed by a normal one. The verdict code for each packet is the length modulo eight, so every code, including the unused ones, is applied many times against different tails.

// File: rtl/phu_pkg.sv
package phu_pkg;
  typedef enum logic [1:0] {
    ST_LOAD = 2'd0,
    ST_RUN  = 2'd1,
    ST_SEND = 2'd2
  } phu_state_e;

  localparam logic [2:0] VC_ABORT = 3'd0;
  localparam logic [2:0] VC_DROP  = 3'd1;
  localparam logic [2:0] VC_HOST  = 3'd2;
  localparam logic [2:0] VC_WIRE  = 3'd3;
  localparam logic [2:0] VC_REDIR = 3'd4;

  localparam logic [1:0] DST_HOST  = 2'd0;
  localparam logic [1:0] DST_WIRE  = 2'd1;
  localparam logic [1:0] DST_REDIR = 2'd2;

  function automatic logic vc_forwards(input logic [2:0] c);
    return (c == VC_HOST) || (c == VC_WIRE) || (c == VC_REDIR);
  endfunction

  function automatic logic [1:0] vc_dest(input logic [2:0] c);
    case (c)
      VC_HOST: return DST_HOST;
      VC_WIRE: return DST_WIRE;
      default: return DST_REDIR;
    endcase
  endfunction
endpackage

// File: rtl/phu_ctrl.sv
module phu_ctrl
  import phu_pkg::*;
#(
  parameter int FB  = 32,
  parameter int NFR = 8,
  localparam int FW   = $clog2(NFR),
  localparam int CW   = $clog2(NFR + 1),
  localparam int LENW = $clog2(NFR * FB + 1),
  localparam int BW   = $clog2(FB + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rx_valid,
  input  logic            rx_last,
  input  logic [BW-1:0]   rx_nbytes,
  output logic            rx_ready,
  output logic            fr_we,
  output logic [FW-1:0]   fr_idx,
  input  logic            vd_valid,
  input  logic [2:0]      vd_code,
  output logic            run_start,
  output logic [LENW-1:0] pkt_len,
  output logic            busy_run,
  output logic            tx_valid,
  input  logic            tx_ready,
  output logic [FW-1:0]   tx_idx,
  output logic            tx_last,
  output logic [BW-1:0]   tx_nbytes,
  output logic [1:0]      tx_dest
);
  phu_state_e      st_q, st_d;
  logic [CW-1:0]   cnt_q, cnt_d;
  logic            ovf_q, ovf_d;
  logic [LENW-1:0] len_q, len_d;
  logic [BW-1:0]   tail_q, tail_d;
  logic [FW-1:0]   lastf_q, lastf_d;
  logic [FW-1:0]   txi_q, txi_d;
  logic [1:0]      dst_q, dst_d;
  logic            strt_q, strt_d;
  logic            take, room, keep, hdr_en;

  assign take   = rx_valid && (st_q == ST_LOAD);
  assign room   = !ovf_q && (cnt_q != CW'(NFR));
  assign keep   = take && room;
  assign hdr_en = keep && rx_last;

  always_comb begin
    st_d    = st_q;
    cnt_d   = cnt_q;
    ovf_d   = ovf_q;
    txi_d   = txi_q;
    dst_d   = dst_q;
    strt_d  = 1'b0;
    len_d   = LENW'(cnt_q) * LENW'(FB) + LENW'(rx_nbytes);
    tail_d  = rx_nbytes;
    lastf_d = cnt_q[FW-1:0];
    case (st_q)
      ST_LOAD: begin
        if (take) begin
          if (rx_last) begin
            cnt_d = '0;
            ovf_d = 1'b0;
            if (room) begin
              st_d   = ST_RUN;
              strt_d = 1'b1;
            end
          end else if (room) begin
            cnt_d = cnt_q + 1'b1;
          end else begin
            ovf_d = 1'b1;
          end
        end
      end
      ST_RUN: begin
        if (vd_valid) begin
          if (vc_forwards(vd_code)) begin
            st_d  = ST_SEND;
            txi_d = '0;
            dst_d = vc_dest(vd_code);
          end else begin
            st_d = ST_LOAD;
          end
        end
      end
      ST_SEND: begin
        if (tx_ready) begin
          if (txi_q == lastf_q) st_d = ST_LOAD;
          else                  txi_d = txi_q + 1'b1;
        end
      end
      default: st_d = ST_LOAD;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_LOAD;
      cnt_q  <= '0;
      ovf_q  <= 1'b0;
      txi_q  <= '0;
      dst_q  <= DST_HOST;
      strt_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      ovf_q  <= ovf_d;
      txi_q  <= txi_d;
      dst_q  <= dst_d;
      strt_q <= strt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q   <= '0;
      tail_q  <= '0;
      lastf_q <= '0;
    end else if (hdr_en) begin
      len_q   <= len_d;
      tail_q  <= tail_d;
      lastf_q <= lastf_d;
    end
  end

  assign rx_ready  = (st_q == ST_LOAD);
  assign fr_we     = keep;
  assign fr_idx    = cnt_q[FW-1:0];
  assign run_start = strt_q;
  assign pkt_len   = len_q;
  assign busy_run  = (st_q == ST_RUN);
  assign tx_valid  = (st_q == ST_SEND);
  assign tx_idx    = txi_q;
  assign tx_last   = tx_valid && (txi_q == lastf_q);
  assign tx_nbytes = tx_last ? tail_q : BW'(FB);
  assign tx_dest   = dst_q;
endmodule

// File: rtl/phu_store.sv
module phu_store #(
  parameter int FB  = 32,
  parameter int NFR = 8,
  localparam int FW = $clog2(NFR),
  localparam int LW = $clog2(FB),
  localparam int AW = $clog2(NFR * FB)
) (
  input  logic            clk,
  input  logic            fr_we,
  input  logic [FW-1:0]   fr_idx,
  input  logic [FB*8-1:0] fr_data,
  input  logic            by_we,
  input  logic [AW-1:0]   by_addr,
  input  logic [7:0]      by_wdata,
  output logic [7:0]      by_rdata,
  input  logic [FW-1:0]   tx_idx,
  output logic [FB*8-1:0] tx_data
);
  logic [LW-1:0]        lane_sel;
  logic [FW-1:0]        row_sel;
  logic [FB-1:0][7:0]   rd_lane;

  assign lane_sel = by_addr[LW-1:0];
  assign row_sel  = by_addr[AW-1:LW];

  for (genvar g = 0; g < FB; g++) begin : g_lane
    logic [7:0] cell_q [NFR];
    logic       byte_hit;
    assign byte_hit = by_we && (lane_sel == LW'(g));

    always_ff @(posedge clk) begin
      if (fr_we) begin
        cell_q[fr_idx] <= fr_data[g*8 +: 8];
      end else if (byte_hit) begin
        cell_q[row_sel] <= by_wdata;
      end
    end

    assign tx_data[g*8 +: 8] = cell_q[tx_idx];
    assign rd_lane[g]        = cell_q[row_sel];
  end

  assign by_rdata = rd_lane[lane_sel];
endmodule

// File: rtl/phu_bytebus.sv
module phu_bytebus #(
  parameter int FB  = 32,
  parameter int NFR = 8,
  localparam int AW   = $clog2(NFR * FB),
  localparam int LENW = $clog2(NFR * FB + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            busy_run,
  input  logic            mem_en,
  input  logic            mem_we,
  input  logic [AW-1:0]   mem_addr,
  input  logic [LENW-1:0] pkt_len,
  input  logic [7:0]      cell_rdata,
  output logic            cell_we,
  output logic [7:0]      mem_rdata
);
  logic       in_len, rd_en;
  logic [7:0] rdata_d, rdata_q;

  assign in_len  = LENW'(mem_addr) < pkt_len;
  assign cell_we = busy_run && mem_en && mem_we && in_len;
  assign rd_en   = busy_run && mem_en && !mem_we;
  assign rdata_d = in_len ? cell_rdata : 8'h00;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata_q <= 8'h00;
    else if (rd_en) rdata_q <= rdata_d;
  end

  assign mem_rdata = rdata_q;
endmodule

// File: rtl/pkt_hold_unit.sv
module pkt_hold_unit #(
  parameter int FRAME_BYTES = 32,
  parameter int MAX_BYTES   = 256
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 rx_valid,
  output logic                                 rx_ready,
  input  logic [FRAME_BYTES*8-1:0]             rx_data,
  input  logic                                 rx_last,
  input  logic [$clog2(FRAME_BYTES+1)-1:0]     rx_nbytes,
  output logic                                 run_start,
  output logic [$clog2(MAX_BYTES+1)-1:0]       pkt_len,
  input  logic                                 mem_en,
  input  logic                                 mem_we,
  input  logic [$clog2(MAX_BYTES)-1:0]         mem_addr,
  input  logic [7:0]                           mem_wdata,
  output logic [7:0]                           mem_rdata,
  input  logic                                 vd_valid,
  input  logic [2:0]                           vd_code,
  output logic                                 tx_valid,
  input  logic                                 tx_ready,
  output logic [FRAME_BYTES*8-1:0]             tx_data,
  output logic                                 tx_last,
  output logic [$clog2(FRAME_BYTES+1)-1:0]     tx_nbytes,
  output logic [1:0]                           tx_dest
);
  localparam int NFR = MAX_BYTES / FRAME_BYTES;
  localparam int FW  = $clog2(NFR);

  logic          fr_we, cell_we, busy_run;
  logic [FW-1:0] fr_idx, tx_idx;
  logic [7:0]    cell_rdata;

  phu_ctrl #(.FB(FRAME_BYTES), .NFR(NFR)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .rx_valid(rx_valid), .rx_last(rx_last), .rx_nbytes(rx_nbytes), .rx_ready(rx_ready),
    .fr_we(fr_we), .fr_idx(fr_idx),
    .vd_valid(vd_valid), .vd_code(vd_code),
    .run_start(run_start), .pkt_len(pkt_len), .busy_run(busy_run),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_idx(tx_idx),
    .tx_last(tx_last), .tx_nbytes(tx_nbytes), .tx_dest(tx_dest)
  );

  phu_store #(.FB(FRAME_BYTES), .NFR(NFR)) u_store (
    .clk(clk),
    .fr_we(fr_we), .fr_idx(fr_idx), .fr_data(rx_data),
    .by_we(cell_we), .by_addr(mem_addr), .by_wdata(mem_wdata), .by_rdata(cell_rdata),
    .tx_idx(tx_idx), .tx_data(tx_data)
  );

  phu_bytebus #(.FB(FRAME_BYTES), .NFR(NFR)) u_bus (
    .clk(clk), .rst_n(rst_n), .busy_run(busy_run),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .pkt_len(pkt_len), .cell_rdata(cell_rdata),
    .cell_we(cell_we), .mem_rdata(mem_rdata)
  );
endmodule

// File: rtl/phu_checker.sv
module phu_checker #(
  parameter int FRAME_BYTES = 32,
  parameter int MAX_BYTES   = 256
) (
  input logic                             clk,
  input logic                             rst_n,
  input logic                             rx_ready,
  input logic                             run_start,
  input logic [$clog2(MAX_BYTES+1)-1:0]   pkt_len,
  input logic                             busy_run,
  input logic                             mem_en,
  input logic                             mem_we,
  input logic [$clog2(MAX_BYTES)-1:0]     mem_addr,
  input logic [7:0]                       mem_rdata,
  input logic                             vd_valid,
  input logic [2:0]                       vd_code,
  input logic                             tx_valid,
  input logic                             tx_ready,
  input logic                             tx_last,
  input logic [$clog2(FRAME_BYTES+1)-1:0] tx_nbytes,
  input logic [1:0]                       tx_dest
);
  localparam int LENW = $clog2(MAX_BYTES + 1);

  p_start_blocks_rx_r1: assert property (@(posedge clk) disable iff (!rst_n)
    run_start |-> !rx_ready);

  p_no_rx_while_tx_r1: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> !rx_ready);

  p_start_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    run_start |=> !run_start);

  p_len_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    run_start |-> (pkt_len != '0) && (pkt_len <= LENW'(MAX_BYTES)));

  p_zero_beyond_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_run && mem_en && !mem_we && (LENW'(mem_addr) >= pkt_len)) |=> (mem_rdata == 8'h00));

  p_drop_silent_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_run && vd_valid && ((vd_code < 3'd2) || (vd_code > 3'd4))) |=> (rx_ready && !tx_valid));

  p_keep_sends_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_run && vd_valid && (vd_code >= 3'd2) && (vd_code <= 3'd4)) |=> (tx_valid && !rx_ready));

  p_full_frames_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_last) |-> (tx_nbytes == ($clog2(FRAME_BYTES+1))'(FRAME_BYTES)));

  p_tx_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_last) && $stable(tx_nbytes) && $stable(tx_dest)));
endmodule

bind pkt_hold_unit phu_checker #(.FRAME_BYTES(FRAME_BYTES), .MAX_BYTES(MAX_BYTES)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_ready(rx_ready), .run_start(run_start),
  .pkt_len(pkt_len), .busy_run(busy_run), .mem_en(mem_en), .mem_we(mem_we),
  .mem_addr(mem_addr), .mem_rdata(mem_rdata), .vd_valid(vd_valid), .vd_code(vd_code),
  .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_last(tx_last),
  .tx_nbytes(tx_nbytes), .tx_dest(tx_dest)
);

// File: tb/sim_pkt_hold_unit.sv
`timescale 1ns/1ps
module sim_pkt_hold_unit;
  localparam int FB   = 32;
  localparam int MAXB = 128;
  localparam int AW   = 7;
  localparam int LENW = 8;
  localparam int BW   = 6;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic            rst_n;
  logic            rx_valid, rx_ready, rx_last;
  logic [FB*8-1:0] rx_data;
  logic [BW-1:0]   rx_nbytes;
  logic            run_start;
  logic [LENW-1:0] pkt_len;
  logic            mem_en, mem_we;
  logic [AW-1:0]   mem_addr;
  logic [7:0]      mem_wdata, mem_rdata;
  logic            vd_valid;
  logic [2:0]      vd_code;
  logic            tx_valid, tx_ready, tx_last;
  logic [FB*8-1:0] tx_data;
  logic [BW-1:0]   tx_nbytes;
  logic [1:0]      tx_dest;

  pkt_hold_unit #(.FRAME_BYTES(FB), .MAX_BYTES(MAXB)) u0 (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .rx_data(rx_data), .rx_last(rx_last), .rx_nbytes(rx_nbytes),
    .run_start(run_start), .pkt_len(pkt_len),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .vd_valid(vd_valid), .vd_code(vd_code),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .tx_last(tx_last), .tx_nbytes(tx_nbytes), .tx_dest(tx_dest)
  );

  int nchk = 0;
  int nerr = 0;
  logic [7:0] expb [MAXB];

  function automatic logic [7:0] pat(input int len, input int i);
    return 8'((len * 7 + i * 3 + 1) & 255);
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic send_pkt(input int len, input bit fits);
    int nf;
    nf = (len + FB - 1) / FB;
    for (int f = 0; f < nf; f++) begin
      @(negedge clk);
      rx_valid  = 1'b1;
      rx_last   = (f == nf - 1);
      rx_nbytes = (f == nf - 1) ? BW'(len - f * FB) : BW'(FB);
      for (int b = 0; b < FB; b++)
        rx_data[b*8 +: 8] = (f * FB + b < len) ? pat(len, f * FB + b) : 8'hEE;
      while (!rx_ready) @(negedge clk);
      @(posedge clk);
    end
    @(negedge clk);
    rx_valid = 1'b0;
    rx_last  = 1'b0;
    if (fits) for (int i = 0; i < len; i++) expb[i] = pat(len, i);
  endtask

  task automatic rd(input int a, output logic [7:0] v);
    @(negedge clk);
    mem_en = 1'b1; mem_we = 1'b0; mem_addr = AW'(a);
    @(negedge clk);
    mem_en = 1'b0;
    v = mem_rdata;
  endtask

  task automatic wr(input int a, input logic [7:0] v);
    @(negedge clk);
    mem_en = 1'b1; mem_we = 1'b1; mem_addr = AW'(a); mem_wdata = v;
    @(negedge clk);
    mem_en = 1'b0; mem_we = 1'b0;
  endtask

  task automatic verdict(input logic [2:0] c);
    @(negedge clk);
    vd_valid = 1'b1; vd_code = c;
    @(negedge clk);
    vd_valid = 1'b0;
  endtask

  task automatic run_one(input int len);
    logic [7:0] v;
    int a, nf, tail, code;
    bit ok;
    logic [7:0] act_b, exp_b;
    send_pkt(len, 1'b1);
    chk(run_start === 1'b1, "R2 start after last frame", run_start, 1);
    chk(pkt_len == LENW'(len), "R3 length", pkt_len, len);
    chk(rx_ready === 1'b0, "R1 ready low while held", rx_ready, 0);
    @(negedge clk);
    chk(run_start === 1'b0, "R2 start one cycle", run_start, 0);
    rd(0, v);
    chk(v == expb[0], "R4 read byte 0", v, expb[0]);
    rd(len - 1, v);
    chk(v == expb[len-1], "R4 read last byte", v, expb[len-1]);
    a = (len * 5) % MAXB;
    rd(a, v);
    if (a < len) chk(v == expb[a], "R4 read inner byte", v, expb[a]);
    else         chk(v == 8'h00, "R5 read past length", v, 0);
    if (len < MAXB) begin
      rd(len, v);
      chk(v == 8'h00, "R5 read at length", v, 0);
    end
    a = (len - 1) / 2;
    expb[a] = ~pat(len, a);
    wr(a, expb[a]);
    rd(a, v);
    chk(v == expb[a], "R6 write then read", v, expb[a]);
    tx_ready = 1'b0;
    code = len % 8;
    verdict(3'(code));
    if (code >= 2 && code <= 4) begin
      nf = (len + FB - 1) / FB;
      tail = len - (nf - 1) * FB;
      chk(tx_valid === 1'b1, "R8 output starts", tx_valid, 1);
      chk(tx_dest == 2'(code - 2), "R8 destination", tx_dest, code - 2);
      @(negedge clk);
      chk(tx_valid === 1'b1 && tx_last === (nf == 1), "R9 held while stalled", tx_last, nf == 1);
      tx_ready = 1'b1;
      for (int f = 0; f < nf; f++) begin
        chk(tx_valid === 1'b1, "R8 frame valid", tx_valid, 1);
        chk(tx_last === (f == nf - 1), "R8 last marker", tx_last, f == nf - 1);
        chk(tx_nbytes == BW'((f == nf - 1) ? tail : FB), "R8 byte count", tx_nbytes,
            (f == nf - 1) ? tail : FB);
        ok = 1'b1; act_b = 8'h00; exp_b = 8'h00;
        for (int b = 0; b < ((f == nf - 1) ? tail : FB); b++)
          if (ok && tx_data[b*8 +: 8] != expb[f*FB + b]) begin
            ok = 1'b0; act_b = tx_data[b*8 +: 8]; exp_b = expb[f*FB + b];
          end
        chk(ok, "R8 R6 frame contents", act_b, exp_b);
        @(negedge clk);
      end
      tx_ready = 1'b0;
      chk(rx_ready === 1'b1 && tx_valid === 1'b0, "R1 ready after send", rx_ready, 1);
    end else begin
      chk(tx_valid === 1'b0, "R7 discard emits nothing", tx_valid, 0);
      chk(rx_ready === 1'b1, "R7 ready after discard", rx_ready, 1);
    end
  endtask

  bit done = 1'b0;

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    rst_n = 1'b0;
    rx_valid = 1'b0; rx_last = 1'b0; rx_data = '0; rx_nbytes = '0;
    mem_en = 1'b0; mem_we = 1'b0; mem_addr = '0; mem_wdata = '0;
    vd_valid = 1'b0; vd_code = '0; tx_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rx_ready === 1'b1, "R1 reset ready", rx_ready, 1);
    chk(run_start === 1'b0, "R2 reset start", run_start, 0);
    chk(tx_valid === 1'b0, "R8 reset output idle", tx_valid, 0);

    verdict(3'd3);
    chk(tx_valid === 1'b0 && rx_ready === 1'b1, "R11 idle verdict ignored", tx_valid, 0);

    for (int len = 1; len <= MAXB; len++) run_one(len);

    send_pkt(150, 1'b0);
    chk(run_start === 1'b0, "R10 no start on overflow", run_start, 0);
    chk(rx_ready === 1'b1, "R10 ready after overflow", rx_ready, 1);
    send_pkt(MAXB + 1, 1'b0);
    chk(run_start === 1'b0, "R10 no start one byte over", run_start, 0);
    send_pkt(40, 1'b1);
    chk(run_start === 1'b1, "R10 next packet starts", run_start, 1);
    chk(pkt_len == LENW'(40), "R10 next packet length", pkt_len, 40);
    rd(33, v);
    chk(v == expb[33], "R10 next packet contents", v, expb[33]);
    verdict(3'd1);
    chk(rx_ready === 1'b1, "R7 drop after overflow", rx_ready, 1);
    verdict(3'd4);
    chk(tx_valid === 1'b0, "R11 verdict after drop ignored", tx_valid, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule